// File: doc/BRIEF.md
# Paired Retirement and Verification Store Queues

This block holds stores on their way from an out-of-order core through a retirement checker to the first-level data cache. Two first-in first-out queues of eight entries sit side by side. The core-side queue takes each store as it leaves the core for the checker, so the core can free its own load/store tracking at that point. While a store waits there, core loads probe the queue alongside the cache and take the forwarded value when there is a match. The checker-side queue takes stores once the checker has verified them, and it writes them to the cache through a single write port whenever the cache grants that port.

The two queues are coupled. Core-side entries are never written to the cache, because the checked copy is the one that reaches memory. The oldest core-side entry is released in the same cycle that the oldest checker-side entry is written. A full core-side queue stalls core retirement. A full checker-side queue stalls the checker pipeline until the cache accepts the head entry.

Top module: `stq_pair`

## Requirements
- R1: After a synchronous active-high reset, both queues are empty: `core_full`, `chk_full`, `l1_wr_req`, `probe_hit` and `probe_replay` are 0, and `probe_data` is 0.
- R2: The core-side queue accepts a store on every cycle in which `core_st_valid` is 1 and `core_full` is 0. `core_full` is 1 while eight stores are held. A store offered while `core_full` is 1 is dropped, and a later probe of its address misses.
- R3: A probe presented in cycle N gives its result in cycle N+1, taken from the core-side contents before the edge. A core-side entry matches a probe when its word address is equal and its byte enables (bit i = byte i, bits 7:0 of data are byte 0) share at least one set bit with the probe's enables. When no entry matches, or no probe was presented, `probe_hit` and `probe_replay` are 0 and `probe_data` is 0.
- R4: When several entries match, only the youngest matching entry decides the result. If its byte enables cover every byte the probe requests, `probe_hit` is 1 and `probe_data` is that entry's full data word.
- R5: If the youngest matching entry does not cover every requested byte, `probe_replay` is 1, `probe_hit` is 0 and `probe_data` is 0.
- R6: `l1_wr_req` is 1 exactly while the checker-side queue is non-empty. `l1_wr_addr`, `l1_wr_be` and `l1_wr_data` show its oldest entry. That entry leaves the queue on an edge where `l1_wr_gnt` is 1. While the grant is 0 the request and its contents hold.
- R7: On the same edge that a checker-side entry is written to the cache, the oldest core-side entry is released. This frees space (`core_full` drops) and removes it from probe matching.
- R8: The checker-side queue accepts a store when `chk_st_valid` is 1 and `chk_full` is 0. `chk_full` is 1 at eight entries, and a store offered while it is full is dropped.
- R9: Only checker-side data reaches the cache port. The core-side copy of a store is never written to it.
- R10: Checker-side entries are written to the cache in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_st_valid | input | 1 | Core store leaving for the checker |
| core_st_addr | input | AW | Word address of the core store |
| core_st_be | input | DW/8 | Byte enables of the core store |
| core_st_data | input | DW | Data of the core store |
| core_full | output | 1 | Core-side queue full; stall retirement |
| probe_valid | input | 1 | Core load probe |
| probe_addr | input | AW | Word address of the load |
| probe_be | input | DW/8 | Bytes the load needs |
| probe_hit | output | 1 | Forwarded value available (one cycle later) |
| probe_replay | output | 1 | Partial overlap; the load must be replayed |
| probe_data | output | DW | Forwarded data word |
| chk_st_valid | input | 1 | Verified store from the checker |
| chk_st_addr | input | AW | Word address of the verified store |
| chk_st_be | input | DW/8 | Byte enables of the verified store |
| chk_st_data | input | DW | Data of the verified store |
| chk_full | output | 1 | Checker-side queue full; stall checker |
| l1_wr_req | output | 1 | Cache write request |
| l1_wr_addr | output | AW | Cache write word address |
| l1_wr_be | output | DW/8 | Cache write byte enables |
| l1_wr_data | output | DW | Cache write data |
| l1_wr_gnt | input | 1 | Cache write port free this cycle |

## Verification
The hardest state to reach from the ports is a full core-side queue that is released by a checker-side write while a further store is being refused. This only happens when the checker has fallen behind and the cache grant is held low. The stimulus fills the core side with five stores that have overlapping addresses and mixed byte enables, then mirrors them into the checker side with the grant held at 0. It tops the core side up to eight and offers a ninth, then opens the grant for one cycle. Probes after that show both the released entry and the dropped store.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int DEF_AW = 32;
  localparam int DEF_DW = 32;
  localparam int DEF_DEPTH = 8;

  typedef enum logic [1:0] {
    FWD_MISS   = 2'd0,
    FWD_HIT    = 2'd1,
    FWD_REPLAY = 2'd2
  } fwd_kind_e;
endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head_data,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count,
  output logic [DEPTH*W-1:0] age_slots,
  output logic [DEPTH-1:0] age_valid
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];

  // entries presented oldest first so a search can favour the youngest
  for (genvar a = 0; a < DEPTH; a++) begin : g_age
    logic [PW-1:0] slot;
    assign slot = rd_ptr + PW'(a);
    assign age_slots[a*W +: W] = mem[slot];
    assign age_valid[a] = (CW'(a) < count);
  end

  initial begin
    if ((1 << PW) != DEPTH) $error("stq_fifo DEPTH must be a power of two");
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full && (count == $past(count))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty); // R6
endmodule

// File: rtl/stq_fwd.sv
module stq_fwd
  import stq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 8,
  localparam int BW = DW / 8,
  localparam int EW = AW + BW + DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEPTH*EW-1:0] age_slots,
  input  logic [DEPTH-1:0]   age_valid,
  input  logic               probe_valid,
  input  logic [AW-1:0]      probe_addr,
  input  logic [BW-1:0]      probe_be,
  output logic               hit,
  output logic               replay,
  output logic [DW-1:0]      data
);
  logic          found;
  logic [BW-1:0] sel_be;
  logic [DW-1:0] sel_data;
  fwd_kind_e     kind;

  always_comb begin
    found    = 1'b0;
    sel_be   = '0;
    sel_data = '0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [EW-1:0] e;
      e = age_slots[a*EW +: EW];
      if (age_valid[a] && (e[EW-1 -: AW] == probe_addr) &&
          ((e[DW +: BW] & probe_be) != '0)) begin
        found    = 1'b1;
        sel_be   = e[DW +: BW];
        sel_data = e[DW-1:0];
      end
    end
  end

  always_comb begin
    if (!probe_valid || !found)           kind = FWD_MISS;
    else if ((probe_be & ~sel_be) == '0)  kind = FWD_HIT;
    else                                  kind = FWD_REPLAY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit    <= 1'b0;
      replay <= 1'b0;
      data   <= '0;
    end else begin
      hit    <= (kind == FWD_HIT);
      replay <= (kind == FWD_REPLAY);
      data   <= (kind == FWD_HIT) ? sel_data : '0;
    end
  end

  AST_FWD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit, replay})); // R5
  AST_FWD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !probe_valid |=> !hit && !replay && (data == '0)); // R3
endmodule

// File: rtl/stq_pair.sv
module stq_pair
  import stq_pkg::*;
#(
  parameter int AW = DEF_AW,
  parameter int DW = DEF_DW,
  parameter int DEPTH = DEF_DEPTH,
  localparam int BW = DW / 8,
  localparam int EW = AW + BW + DW,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_st_valid,
  input  logic [AW-1:0] core_st_addr,
  input  logic [BW-1:0] core_st_be,
  input  logic [DW-1:0] core_st_data,
  output logic          core_full,
  input  logic          probe_valid,
  input  logic [AW-1:0] probe_addr,
  input  logic [BW-1:0] probe_be,
  output logic          probe_hit,
  output logic          probe_replay,
  output logic [DW-1:0] probe_data,
  input  logic          chk_st_valid,
  input  logic [AW-1:0] chk_st_addr,
  input  logic [BW-1:0] chk_st_be,
  input  logic [DW-1:0] chk_st_data,
  output logic          chk_full,
  output logic          l1_wr_req,
  output logic [AW-1:0] l1_wr_addr,
  output logic [BW-1:0] l1_wr_be,
  output logic [DW-1:0] l1_wr_data,
  input  logic          l1_wr_gnt
);
  logic [CW-1:0]       core_cnt, chk_cnt;
  logic                core_empty, chk_empty;
  logic [EW-1:0]       core_head_unused, chk_head;
  logic [DEPTH*EW-1:0] core_slots, chk_slots_unused;
  logic [DEPTH-1:0]    core_valid, chk_valid_unused;
  logic                drain;

  assign l1_wr_req = !chk_empty;
  assign drain     = l1_wr_req && l1_wr_gnt;

  stq_fifo #(.W(EW), .DEPTH(DEPTH)) u_core_q (
    .clk(clk), .rst(rst),
    .push(core_st_valid), .push_data({core_st_addr, core_st_be, core_st_data}),
    .pop(drain), .head_data(core_head_unused),
    .full(core_full), .empty(core_empty), .count(core_cnt),
    .age_slots(core_slots), .age_valid(core_valid)
  );

  stq_fifo #(.W(EW), .DEPTH(DEPTH)) u_chk_q (
    .clk(clk), .rst(rst),
    .push(chk_st_valid), .push_data({chk_st_addr, chk_st_be, chk_st_data}),
    .pop(drain), .head_data(chk_head),
    .full(chk_full), .empty(chk_empty), .count(chk_cnt),
    .age_slots(chk_slots_unused), .age_valid(chk_valid_unused)
  );

  assign l1_wr_addr = chk_head[EW-1 -: AW];
  assign l1_wr_be   = chk_head[DW +: BW];
  assign l1_wr_data = chk_head[DW-1:0];

  stq_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
    .clk(clk), .rst(rst),
    .age_slots(core_slots), .age_valid(core_valid),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_be(probe_be),
    .hit(probe_hit), .replay(probe_replay), .data(probe_data)
  );

  AST_CHK_WITHIN_CORE: assert property (@(posedge clk) disable iff (rst)
    (chk_cnt <= core_cnt) && (!core_empty || chk_empty)); // R7
  AST_HOLD_NO_GNT: assert property (@(posedge clk) disable iff (rst)
    (l1_wr_req && !l1_wr_gnt) |=> l1_wr_req && $stable(l1_wr_addr) &&
      $stable(l1_wr_be) && $stable(l1_wr_data)); // R6
  AST_PAIRED_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (drain && !(core_st_valid && !core_full)) |=>
      (core_cnt == $past(core_cnt) - 1'b1)); // R7
  AST_CHK_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (chk_full && !drain) |=> chk_full); // R8
endmodule

// File: tb/stq_pair_bench.sv
module stq_pair_bench;
  logic        clk = 0, rst = 1;
  logic        core_st_valid = 0, probe_valid = 0, chk_st_valid = 0, l1_wr_gnt = 0;
  logic [31:0] core_st_addr = 0, core_st_data = 0, probe_addr = 0, chk_st_addr = 0, chk_st_data = 0;
  logic [3:0]  core_st_be = 0, probe_be = 0, chk_st_be = 0;
  logic        core_full, probe_hit, probe_replay, chk_full, l1_wr_req;
  logic [31:0] probe_data, l1_wr_addr, l1_wr_data;
  logic [3:0]  l1_wr_be;
  int nchecks = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stq_pair u_stq_pair (.*);

  typedef struct packed {
    logic [31:0] a; logic [3:0] be; logic h; logic r; logic [31:0] d;
  } pv_t;
  localparam int NP = 11;
  localparam pv_t PTAB [NP] = '{
    '{32'h10, 4'hF, 1'b0, 1'b1, 32'h0},          // R4 R5 youngest partial
    '{32'h10, 4'h1, 1'b1, 1'b0, 32'h000000CC},   // R4 youngest covers
    '{32'h10, 4'h2, 1'b1, 1'b0, 32'h22222222},   // R4 skip non-overlap
    '{32'h20, 4'h3, 1'b1, 1'b0, 32'h0000AAAA},
    '{32'h20, 4'h1, 1'b1, 1'b0, 32'h0000AAAA},
    '{32'h20, 4'hF, 1'b0, 1'b1, 32'h0},          // R5
    '{32'h20, 4'hC, 1'b0, 1'b0, 32'h0},          // R3 no overlap
    '{32'h30, 4'h4, 1'b1, 1'b0, 32'hBBBB0000},
    '{32'h30, 4'h3, 1'b0, 1'b0, 32'h0},
    '{32'h30, 4'h6, 1'b0, 1'b1, 32'h0},
    '{32'h40, 4'hF, 1'b0, 1'b0, 32'h0}
  };
  localparam logic [31:0] XM = 32'h5A5A5A5A;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic core_push(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    core_st_valid = 1; core_st_addr = a; core_st_be = be; core_st_data = d;
    tick(); core_st_valid = 0;
  endtask

  task automatic chk_push(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    chk_st_valid = 1; chk_st_addr = a; chk_st_be = be; chk_st_data = d;
    tick(); chk_st_valid = 0;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [3:0] be,
                       input logic eh, input logic er, input logic [31:0] ed);
    probe_valid = 1; probe_addr = a; probe_be = be;
    tick(); probe_valid = 0;
    check({tag, " hit"}, {31'b0, probe_hit}, {31'b0, eh});
    check({tag, " replay"}, {31'b0, probe_replay}, {31'b0, er});
    check({tag, " data"}, probe_data, ed);
  endtask

  task automatic drain(input string tag, input logic [31:0] ea, input logic [31:0] ed);
    check({tag, " req"}, {31'b0, l1_wr_req}, 32'd1);
    check({tag, " addr"}, l1_wr_addr, ea);
    check({tag, " data"}, l1_wr_data, ed);
    l1_wr_gnt = 1; tick(); l1_wr_gnt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++; nchecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    check("R1 core_full", {31'b0, core_full}, 0);
    check("R1 chk_full", {31'b0, chk_full}, 0);
    check("R1 l1_wr_req", {31'b0, l1_wr_req}, 0);
    check("R1 probe_hit", {31'b0, probe_hit}, 0);
    check("R1 probe_data", probe_data, 0);
    probe("R3 empty", 32'h10, 4'hF, 0, 0, 0);

    core_push(32'h10, 4'hF, 32'h11111111);
    core_push(32'h20, 4'h3, 32'h0000AAAA);
    core_push(32'h10, 4'hF, 32'h22222222);
    core_push(32'h30, 4'hC, 32'hBBBB0000);
    core_push(32'h10, 4'h1, 32'h000000CC);
    // R3 R4 R5 table walk
    for (int i = 0; i < NP; i++)
      probe($sformatf("R3 R4 R5 vec%0d", i), PTAB[i].a, PTAB[i].be, PTAB[i].h, PTAB[i].r, PTAB[i].d);
    tick();
    check("R3 idle hit", {31'b0, probe_hit}, 0);

    // R9: checker copies differ from core copies; grant held low
    chk_push(32'h10, 4'hF, 32'h11111111 ^ XM);
    check("R6 req on nonempty", {31'b0, l1_wr_req}, 1);
    chk_push(32'h20, 4'h3, 32'h0000AAAA ^ XM);
    chk_push(32'h10, 4'hF, 32'h22222222 ^ XM);
    chk_push(32'h30, 4'hC, 32'hBBBB0000 ^ XM);
    chk_push(32'h10, 4'h1, 32'h000000CC ^ XM);
    repeat (3) tick();
    check("R6 hold addr", l1_wr_addr, 32'h10);
    check("R9 checker data", l1_wr_data, 32'h11111111 ^ XM);

    core_push(32'h50, 4'hF, 32'h55555555);
    core_push(32'h60, 4'hF, 32'h66666666);
    check("R2 not full at 7", {31'b0, core_full}, 0);
    core_push(32'h70, 4'hF, 32'h77777777);
    check("R2 full at 8", {31'b0, core_full}, 1);
    core_push(32'h80, 4'hF, 32'h88888888);
    check("R2 still full", {31'b0, core_full}, 1);
    drain("R6 R9 R10 d0", 32'h10, 32'h11111111 ^ XM);
    check("R7 full released", {31'b0, core_full}, 0);
    probe("R2 dropped store", 32'h80, 4'hF, 0, 0, 0);
    drain("R10 d1", 32'h20, 32'h0000AAAA ^ XM);
    probe("R7 released 0x20", 32'h20, 4'h1, 0, 0, 0);
    drain("R10 d2", 32'h10, 32'h22222222 ^ XM);
    drain("R10 d3", 32'h30, 32'hBBBB0000 ^ XM);
    drain("R10 d4", 32'h10, 32'h000000CC ^ XM);
    check("R6 req drops", {31'b0, l1_wr_req}, 0);
    probe("R7 released 0x10", 32'h10, 4'h1, 0, 0, 0);
    probe("R7 kept 0x60", 32'h60, 4'hF, 1, 0, 32'h66666666);

    // R8 checker full
    for (int i = 0; i < 5; i++) core_push(32'h90 + 32'(i) * 16, 4'hF, 32'(i));
    for (int i = 0; i < 8; i++) chk_push(32'h100 + 32'(i), 4'hF, 32'(i));
    check("R8 chk full", {31'b0, chk_full}, 1);
    chk_push(32'h1FF, 4'hF, 32'hDEAD);
    check("R8 still full", {31'b0, chk_full}, 1);
    for (int i = 0; i < 8; i++) drain($sformatf("R8 R10 d%0d", i), 32'h100 + 32'(i), 32'(i));
    check("R8 dropped not drained", {31'b0, l1_wr_req}, 0);
    check("R7 core empty", {31'b0, core_full}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule